// File: doc/BRIEF.md
# Receive Frame Slot Manager

This block parks finished frames from the bit-level receiver of a single-wire home-entertainment control bus until software has read them. A byte stream fills a staging buffer. When the receiver signals the end of a frame and reports that the destination address matched, the staged bytes go into one of three slots. Each slot holds up to sixteen bytes (the header is byte 0) and a 5-bit length.

Each slot carries a 2-bit age rank, and the ranks are packed into one order word. Software reads that word and drains the slots from oldest to newest, whatever their index. A slot is released by pulsing its clear bit high and then low in a 4-bit control register. Bit 3 of the same register chooses between the three-slot mode and a legacy mode that uses slot 0 only. A frame that finds no free slot is discarded and raises a sticky overflow flag.

Top module: `rxslot_mgr`

## Requirements
- R1: After reset, `orderStatus`, `readyIrq`, `overflow`, `slotLen` and `ctrlValue` are all zero. Legacy mode (bit 3 = 0) is therefore active.
- R2: `orderStatus` holds slot i's field in bits [2i+1:2i]. The value 0 marks an empty slot, 1 the oldest frame held, 2 the second oldest and 3 the third oldest. Occupied slots always carry the ranks 1..N with no gaps.
- R3: In three-slot mode (control bit 3 = 1), a frame that ends with `rxAddrHit` high goes into the lowest-index free slot. Its rank is the number of slots already occupied plus one, and it is visible in the cycle after `rxFrameDone`.
- R4: A frame that ends with `rxAddrHit` low, or that carries zero bytes, is discarded. No slot, rank or flag changes.
- R5: A slot's length equals the number of bytes received, capped at 16. Bytes past the sixteenth are dropped. `rdData` returns byte `rdIdx` of slot `rdSlot`, and the header is at index 0.
- R6: Control bit i (i = 0..2) releases slot i only on a write that takes that bit from 1 to 0. Writing the 1 alone releases nothing. Every occupied slot whose rank was higher than a released slot's rank moves down by one.
- R7: Writing 0xF and then 0x8 to the control register empties all three slots and leaves three-slot mode selected. After the 0xF write alone, the slots are still held.
- R8: If a frame arrives when no slot is free, it is dropped, held contents are unchanged and `overflow` is set. `overflow` stays high until the next control write clears it.
- R9: In legacy mode (bit 3 = 0), only slot 0 is used. While slot 0 is full, its order field reads 1 and any further frame is dropped with overflow.
- R10: `readyIrq[i]` is high exactly while slot i holds a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxByteValid | input | 1 | A received byte is present on `rxByte` |
| rxByte | input | 8 | Received byte |
| rxFrameDone | input | 1 | End-of-frame strobe |
| rxAddrHit | input | 1 | Destination matched; qualifies `rxFrameDone` |
| ctrlWrEn | input | 1 | Write strobe for the control register |
| ctrlWrData | input | 4 | Control value: [2:0] clear bits, [3] three-slot mode |
| ctrlValue | output | 4 | Current control register |
| rdSlot | input | 2 | Slot to read |
| rdIdx | input | 4 | Byte index in the slot |
| rdData | output | 8 | Selected byte |
| slotLen | output | 15 | Length of slot i in bits [5i+4:5i] |
| orderStatus | output | 6 | Packed age ranks |
| readyIrq | output | 3 | Per-slot ready interrupt |
| overflow | output | 1 | Sticky dropped-frame flag |

## Verification
Every registered result is due one clock edge after its stimulus. This covers a slot's occupancy, rank, length and interrupt after `rxFrameDone`, the rank shuffle and clear effects after a control write, and the overflow flag after a drop. `rdData` is combinational from the stored bytes. The bench drives each stimulus on a falling edge. It releases the stimulus on the next falling edge and samples there, half a period after the one rising edge that registers the result. Nothing is read before that edge.

// File: rtl/rxslot_pkg.sv
package rxslot_pkg;
  localparam int SLOTS     = 3;
  localparam int MAX_BYTES = 16;
  localparam int BYTE_W    = 8;
  localparam int LEN_W     = $clog2(MAX_BYTES + 1);
  localparam int IDX_W     = $clog2(MAX_BYTES);
  localparam int RANK_W    = $clog2(SLOTS + 1);
  localparam int SLOT_W    = $clog2(SLOTS + 1);
  localparam int CTRL_W    = SLOTS + 1;

  typedef struct packed {
    logic              stageClr;
    logic              storeEn;
    logic [SLOT_W-1:0] storeSlot;
  } dpCmd_t;
endpackage

// File: rtl/rxslot_datapath.sv
module rxslot_datapath
  import rxslot_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     rxByteValid,
  input  logic [BYTE_W-1:0]        rxByte,
  input  dpCmd_t                   cmd,
  output logic                     stageEmpty,
  input  logic [SLOT_W-1:0]        rdSlot,
  input  logic [IDX_W-1:0]         rdIdx,
  output logic [BYTE_W-1:0]        rdData,
  output logic [SLOTS*LEN_W-1:0]   slotLen
);
  logic [BYTE_W-1:0] stage [MAX_BYTES];
  logic [LEN_W-1:0]  stageCnt;
  logic [BYTE_W-1:0] store [SLOTS][MAX_BYTES];
  logic [LEN_W-1:0]  lenQ  [SLOTS];
  logic              stageRoom;

  assign stageRoom  = stageCnt < LEN_W'(MAX_BYTES);
  assign stageEmpty = (stageCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageCnt <= '0;
    else if (cmd.stageClr) stageCnt <= '0;
    else if (rxByteValid && stageRoom) stageCnt <= stageCnt + LEN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!cmd.stageClr && rxByteValid && stageRoom)
      stage[stageCnt[IDX_W-1:0]] <= rxByte;
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic hit;
    assign hit = cmd.storeEn && (cmd.storeSlot == SLOT_W'(s));
    always_ff @(posedge clk) begin
      if (hit) store[s] <= stage;
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) lenQ[s] <= '0;
      else if (hit) lenQ[s] <= stageCnt;
    end
    assign slotLen[s*LEN_W +: LEN_W] = lenQ[s];
  end

  always_comb begin
    rdData = '0;
    for (int s = 0; s < SLOTS; s++)
      if (rdSlot == SLOT_W'(s)) rdData = store[s][rdIdx];
  end

  // R5
  stage_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    stageCnt <= LEN_W'(MAX_BYTES));
  // R4
  no_empty_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.storeEn |-> !stageEmpty);
endmodule

// File: rtl/rxslot_ctrl.sv
module rxslot_ctrl
  import rxslot_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     rxFrameDone,
  input  logic                     rxAddrHit,
  input  logic                     stageEmpty,
  input  logic                     ctrlWrEn,
  input  logic [CTRL_W-1:0]        ctrlWrData,
  output dpCmd_t                   cmd,
  output logic [CTRL_W-1:0]        ctrlValue,
  output logic [SLOTS*RANK_W-1:0]  orderStatus,
  output logic [SLOTS-1:0]         readyIrq,
  output logic                     overflow
);
  localparam int MODE_BIT = SLOTS;

  logic [CTRL_W-1:0] ctrlQ;
  logic [SLOTS-1:0]  valid, freeNow, surv;
  logic [RANK_W-1:0] rank     [SLOTS];
  logic [RANK_W-1:0] survRank [SLOTS];
  logic [RANK_W-1:0] survCnt;
  logic [SLOT_W-1:0] target;
  logic              hasRoom, accept, multi;

  assign multi = ctrlQ[MODE_BIT];

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      freeNow[i] = ctrlWrEn && ctrlQ[i] && !ctrlWrData[i];
      surv[i]    = valid[i] && !freeNow[i];
    end
    survCnt = RANK_W'($countones(surv));
    for (int i = 0; i < SLOTS; i++) begin
      survRank[i] = '0;
      if (surv[i])
        for (int j = 0; j < SLOTS; j++)
          if (surv[j] && rank[j] <= rank[i]) survRank[i] = survRank[i] + RANK_W'(1);
    end
    hasRoom = 1'b0;
    target  = '0;
    for (int i = 0; i < SLOTS; i++)
      if (!hasRoom && !surv[i] && (multi || i == 0)) begin
        hasRoom = 1'b1;
        target  = SLOT_W'(i);
      end
  end

  assign accept        = rxFrameDone && rxAddrHit && !stageEmpty;
  assign cmd.stageClr  = rxFrameDone;
  assign cmd.storeEn   = accept && hasRoom;
  assign cmd.storeSlot = target;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ    <= '0;
      valid    <= '0;
      overflow <= 1'b0;
      for (int i = 0; i < SLOTS; i++) rank[i] <= '0;
    end else begin
      if (ctrlWrEn) ctrlQ <= ctrlWrData;
      for (int i = 0; i < SLOTS; i++) begin
        if (cmd.storeEn && target == SLOT_W'(i)) begin
          valid[i] <= 1'b1;
          rank[i]  <= survCnt + RANK_W'(1);
        end else begin
          valid[i] <= surv[i];
          rank[i]  <= survRank[i];
        end
      end
      if (accept && !hasRoom) overflow <= 1'b1;
      else if (ctrlWrEn)      overflow <= 1'b0;
    end
  end

  always_comb begin
    for (int i = 0; i < SLOTS; i++)
      orderStatus[i*RANK_W +: RANK_W] = multi ? rank[i] : '0;
    if (!multi) orderStatus[RANK_W-1:0] = valid[0] ? RANK_W'(1) : '0;
  end

  assign readyIrq  = valid;
  assign ctrlValue = ctrlQ;

  for (genvar i = 0; i < SLOTS; i++) begin : g_chk
    // R2
    rank_range_chk: assert property (@(posedge clk) disable iff (!rstN)
      valid[i] |-> (rank[i] != '0) && (rank[i] <= RANK_W'($countones(valid))));
    // R2
    rank_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
      !valid[i] |-> rank[i] == '0);
    // R6
    release_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(valid[i]) |-> $past(ctrlWrEn) && $past(ctrlQ[i]) && !$past(ctrlWrData[i]));
    // R3
    newest_rank_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(valid[i]) |-> rank[i] == RANK_W'($countones(valid)));
    for (genvar j = i + 1; j < SLOTS; j++) begin : g_pair
      // R2
      rank_unique_chk: assert property (@(posedge clk) disable iff (!rstN)
        (valid[i] && valid[j]) |-> rank[i] != rank[j]);
    end
    if (i > 0) begin : g_legacy
      // R9
      legacy_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
        $rose(valid[i]) |-> $past(ctrlQ[MODE_BIT]));
    end
  end
  // R8
  overflow_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $past(rxFrameDone && rxAddrHit));
endmodule

// File: rtl/rxslot_mgr.sv
module rxslot_mgr
  import rxslot_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     rxByteValid,
  input  logic [BYTE_W-1:0]        rxByte,
  input  logic                     rxFrameDone,
  input  logic                     rxAddrHit,
  input  logic                     ctrlWrEn,
  input  logic [CTRL_W-1:0]        ctrlWrData,
  output logic [CTRL_W-1:0]        ctrlValue,
  input  logic [SLOT_W-1:0]        rdSlot,
  input  logic [IDX_W-1:0]         rdIdx,
  output logic [BYTE_W-1:0]        rdData,
  output logic [SLOTS*LEN_W-1:0]   slotLen,
  output logic [SLOTS*RANK_W-1:0]  orderStatus,
  output logic [SLOTS-1:0]         readyIrq,
  output logic                     overflow
);
  dpCmd_t cmd;
  logic   stageEmpty;

  rxslot_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rxFrameDone(rxFrameDone), .rxAddrHit(rxAddrHit),
    .stageEmpty(stageEmpty), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .cmd(cmd), .ctrlValue(ctrlValue), .orderStatus(orderStatus),
    .readyIrq(readyIrq), .overflow(overflow)
  );

  rxslot_datapath u_dp (
    .clk(clk), .rstN(rstN), .rxByteValid(rxByteValid), .rxByte(rxByte),
    .cmd(cmd), .stageEmpty(stageEmpty), .rdSlot(rdSlot), .rdIdx(rdIdx),
    .rdData(rdData), .slotLen(slotLen)
  );
endmodule

// File: tb/tb_rxslot_mgr.sv
`timescale 1ns/1ps
module tb_rxslot_mgr;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxByteValid = 1'b0;
  logic [7:0] rxByte = '0;
  logic       rxFrameDone = 1'b0;
  logic       rxAddrHit = 1'b0;
  logic       ctrlWrEn = 1'b0;
  logic [3:0] ctrlWrData = '0;
  logic [3:0] ctrlValue;
  logic [1:0] rdSlot = '0;
  logic [3:0] rdIdx = '0;
  logic [7:0] rdData;
  logic [14:0] slotLen;
  logic [5:0] orderStatus;
  logic [2:0] readyIrq;
  logic       overflow;
  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;

  rxslot_mgr dut (
    .clk(clk), .rstN(rstN), .rxByteValid(rxByteValid), .rxByte(rxByte),
    .rxFrameDone(rxFrameDone), .rxAddrHit(rxAddrHit), .ctrlWrEn(ctrlWrEn),
    .ctrlWrData(ctrlWrData), .ctrlValue(ctrlValue), .rdSlot(rdSlot), .rdIdx(rdIdx),
    .rdData(rdData), .slotLen(slotLen), .orderStatus(orderStatus),
    .readyIrq(readyIrq), .overflow(overflow)
  );

  // fields: hit, nBytes[4:0], seed[7:0], expSlot[1:0] (3 = none), expOrder[5:0], expIrq[2:0], expOvf
  localparam int NV = 6;
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, 5'd3,  8'h10, 2'd0, 6'b000001, 3'b001, 1'b0},  // R3 first frame
    {1'b0, 5'd4,  8'h20, 2'd3, 6'b000001, 3'b001, 1'b0},  // R4 no address hit
    {1'b1, 5'd0,  8'h00, 2'd3, 6'b000001, 3'b001, 1'b0},  // R4 empty frame
    {1'b1, 5'd16, 8'h40, 2'd1, 6'b001001, 3'b011, 1'b0},  // R3 second
    {1'b1, 5'd20, 8'h80, 2'd2, 6'b111001, 3'b111, 1'b0},  // R5 capped
    {1'b1, 5'd2,  8'hC0, 2'd3, 6'b111001, 3'b111, 1'b1}   // R8 full
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendFrame(input logic hit, input int n, input logic [7:0] seed);
    for (int k = 0; k < n; k++) begin
      rxByteValid = 1'b1;
      rxByte = seed + 8'(k);
      @(negedge clk);
    end
    rxByteValid = 1'b0;
    rxFrameDone = 1'b1;
    rxAddrHit = hit;
    @(negedge clk);
    rxFrameDone = 1'b0;
    rxAddrHit = 1'b0;
  endtask

  task automatic ctrlWrite(input logic [3:0] v);
    ctrlWrEn = 1'b1;
    ctrlWrData = v;
    @(negedge clk);
    ctrlWrEn = 1'b0;
  endtask

  task automatic chkSlot(input string req, input int s, input int len, input logic [7:0] seed);
    rdSlot = 2'(s);
    chk(req, 32'(slotLen[s*5 +: 5]), 32'(len));
    for (int k = 0; k < len; k++) begin
      rdIdx = 4'(k);
      #0.1;
      chk(req, 32'(rdData), 32'(seed + 8'(k)));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", 32'(orderStatus), 0);
    chk("R1", 32'(readyIrq), 0);
    chk("R1", 32'(overflow), 0);
    chk("R1", 32'(slotLen), 0);
    chk("R1", 32'(ctrlValue), 0);

    ctrlWrite(4'h8);
    chk("R7", 32'(ctrlValue), 32'h8);
    for (int v = 0; v < NV; v++) begin
      logic [25:0] e;
      int n;
      e = VEC[v];
      n = int'(e[24:20]);
      sendFrame(e[25], n, e[19:12]);
      chk("R2", 32'(orderStatus), 32'(e[9:4]));
      chk("R10", 32'(readyIrq), 32'(e[3:1]));
      chk("R8", 32'(overflow), 32'(e[0]));
      if (e[11:10] != 2'd3)
        chkSlot("R5", int'(e[11:10]), (n > 16) ? 16 : n, e[19:12]);
    end
    chkSlot("R8", 0, 3, 8'h10);

    ctrlWrite(4'hA);
    chk("R6", 32'(readyIrq), 32'b111);
    chk("R8", 32'(overflow), 0);
    ctrlWrite(4'h8);
    chk("R6", 32'(orderStatus), 32'b100001);
    chk("R10", 32'(readyIrq), 32'b101);

    sendFrame(1'b1, 5, 8'h50);
    chk("R3", 32'(orderStatus), 32'b101101);
    chk("R3", 32'(readyIrq), 32'b111);
    chkSlot("R3", 1, 5, 8'h50);

    ctrlWrite(4'h9);
    chk("R6", 32'(readyIrq), 32'b111);
    ctrlWrite(4'h8);
    chk("R6", 32'(orderStatus), 32'b011000);
    chk("R6", 32'(readyIrq), 32'b110);

    ctrlWrite(4'hF);
    chk("R7", 32'(readyIrq), 32'b110);
    chk("R7", 32'(ctrlValue), 32'hF);
    ctrlWrite(4'h8);
    chk("R7", 32'(readyIrq), 0);
    chk("R7", 32'(orderStatus), 0);
    chk("R7", 32'(ctrlValue), 32'h8);

    ctrlWrite(4'h0);
    sendFrame(1'b1, 2, 8'h30);
    chk("R9", 32'(orderStatus), 32'b000001);
    chk("R9", 32'(readyIrq), 32'b001);
    sendFrame(1'b1, 3, 8'h60);
    chk("R9", 32'(readyIrq), 32'b001);
    chk("R9", 32'(overflow), 1);
    chk("R9", 32'(orderStatus), 32'b000001);
    chkSlot("R9", 0, 2, 8'h30);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule